// File: doc/BRIEF.md
# Multi-Format Serial PCM Audio Port

This block is a serial audio receiver and transmitter that runs on a fast system clock. It oversamples an external bit clock, an active-low word sync and a serial data line. It rebuilds stereo PCM samples from them and hands each left/right pair to the core on a valid/ready stream. In the other direction it takes processed pairs from a second valid/ready stream and shifts them out on a serial data output, bit-aligned to the same bit clock and word sync.

A 2-bit format input selects the framing. Three formats use 24 bit-clock slots per channel half, with the word right-aligned against the next sync transition: 16, 18 or 20 bits. The fourth format uses 32 slots per half, with a 16-bit word that starts one slot after the sync transition. Received words are presented left-aligned in a 20-bit sample field. Transmitted words carry the upper 16 bits of the sample, and any longer word length is filled with zero low bits.

Stream rules: a received pair is held on `rx_left_o`/`rx_right_o` with `rx_valid_o` high until `rx_ready_i` is seen high on a clock edge. If the core has not taken a pair when the next one completes, the newer pair replaces it, because the serial side cannot be stalled. On the transmit side, one pair is staged while `tx_ready_o` is high. The staged pair goes out in the frame after the one in which it was accepted, so there is one frame of latency. `tx_ready_o` comes back at the start of that frame.

Top module: `pcm_serial_port`

## Requirements
- R1: With format code 00, each channel half is 24 slots long, and the 16-bit word occupies the last 16 slots before the sync transition, MSB first.
- R2: With format code 01, the 18-bit word occupies the last 18 slots of a 24-slot half, and the received sample holds it in bits 19..2 with bits 1..0 zero.
- R3: With format code 10, the 20-bit word occupies the last 20 slots of a 24-slot half and fills the received sample.
- R4: With format code 11, each half is 32 slots long, and the 16-bit word sits in slots 1 to 16 counted from the sync transition (slot 0), MSB first.
- R5: Sync low marks the left word and sync high marks the right word. A pair is offered after its right word completes. Received samples are left-aligned in 20 bits, with unused low bits zero.
- R6: While `rx_valid_o` is high and `rx_ready_i` is low, the pair stays valid and unchanged unless a newer pair completes, and a newer pair replaces it.
- R7: A transmit pair is accepted when `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` then stays low until the next frame starts at left slot 0.
- R8: The transmitted word for each channel is sample bits 19..4, padded with zero low bits to the format's word length. It is placed in the same slots as on input, and all other slots carry zero.
- R9: A frame that starts with no pair staged is sent as all zeros.
- R10: Input bits are taken at rising bit-clock edges. `sdata_o` changes only on the system clock after a detected falling bit-clock edge.
- R11: After reset, `rx_valid_o` is 0, `tx_ready_o` is 1 and `sdata_o` is 0. No pair is produced, and nothing but zeros is sent, until a first sync transition has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_i | input | 2 | Frame format code |
| bclk_i | input | 1 | Serial bit clock |
| wsync_n_i | input | 1 | Word sync, low = left, high = right |
| sdata_i | input | 1 | Serial data in |
| sdata_o | output | 1 | Serial data out |
| rx_valid_o | output | 1 | Received pair valid |
| rx_ready_i | input | 1 | Core accepts received pair |
| rx_left_o | output | 20 | Received left sample, left-aligned |
| rx_right_o | output | 20 | Received right sample, left-aligned |
| tx_valid_i | input | 1 | Transmit pair valid |
| tx_ready_o | output | 1 | Staging register free |
| tx_left_i | input | 20 | Left sample to transmit |
| tx_right_i | input | 20 | Right sample to transmit |

## Verification
The bench builds the block with its defaults: a 20-bit sample field and a two-stage input synchronizer. It drives a bit clock of twelve system cycles. That leaves enough margin for the three-cycle path from a falling edge to `sdata_o` to settle before the next rising edge, where the bench samples it. With these values all four format codes can be reached in one run. The run covers the end-of-half capture used by the right-aligned formats and the in-half capture of the delayed format, including the extra pair the latter completes inside the flush frame. The 20-bit field also shows zero padding and truncation at every word length.

// File: rtl/pcm_sp_pkg.sv
package pcm_sp_pkg;

  typedef enum logic [1:0] {
    FMT_R16 = 2'b00,
    FMT_R18 = 2'b01,
    FMT_R20 = 2'b10,
    FMT_D16 = 2'b11
  } fmt_e;

  function automatic int word_bits(fmt_e f);
    case (f)
      FMT_R18: return 18;
      FMT_R20: return 20;
      default: return 16;
    endcase
  endfunction

  function automatic int half_slots(fmt_e f);
    return (f == FMT_D16) ? 32 : 24;
  endfunction

  function automatic logic is_delayed(fmt_e f);
    return f == FMT_D16;
  endfunction

endpackage

// File: rtl/pcm_sp_sync.sv
module pcm_sp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic ws_n,
  input  logic sd,
  output logic rise,
  output logic fall,
  output logic ws_s,
  output logic sd_s
);
  logic [STAGES-1:0] b_q, w_q, d_q;
  logic              b_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_q    <= '0;
      w_q    <= '1;
      d_q    <= '0;
      b_prev <= 1'b0;
    end else begin
      b_q    <= {b_q[STAGES-2:0], bclk};
      w_q    <= {w_q[STAGES-2:0], ws_n};
      d_q    <= {d_q[STAGES-2:0], sd};
      b_prev <= b_q[STAGES-1];
    end
  end

  assign rise = b_q[STAGES-1] & ~b_prev;
  assign fall = ~b_q[STAGES-1] & b_prev;
  assign ws_s = w_q[STAGES-1];
  assign sd_s = d_q[STAGES-1];
endmodule

// File: rtl/pcm_sp_rx.sv
module pcm_sp_rx
  import pcm_sp_pkg::*;
#(
  parameter int SMP_W = 20,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_e             fmt,
  input  logic             rise,
  input  logic             ws,
  input  logic             sd,
  input  logic             rx_ready,
  output logic [CNT_W-1:0] slot,
  output logic             ws_q,
  output logic             locked,
  output logic             rx_valid,
  output logic [SMP_W-1:0] rx_left,
  output logic [SMP_W-1:0] rx_right,
  output logic             pair_done
);
  logic [SMP_W-1:0] sh, sh_nx, raw, mask, aligned, left_hold;
  logic [CNT_W-1:0] slot_nx;
  logic             new_half, shift_en, word_done, word_right;
  int               w_i;

  always_comb begin
    w_i      = word_bits(fmt);
    new_half = ws != ws_q;
    if (new_half)          slot_nx = '0;
    else if (&slot)        slot_nx = slot;
    else                   slot_nx = slot + 1'b1;
    sh_nx    = {sh[SMP_W-2:0], sd};
    shift_en = is_delayed(fmt) ? (int'(slot_nx) >= 1 && int'(slot_nx) <= 16) : 1'b1;
    if (is_delayed(fmt)) begin
      word_done  = rise & locked & ~new_half & (int'(slot_nx) == 16);
      word_right = ws;
      raw        = sh_nx;
    end else begin
      word_done  = rise & locked & new_half;
      word_right = ws_q;
      raw        = sh;
    end
    mask      = (SMP_W'(1) << w_i) - SMP_W'(1);
    aligned   = (raw & mask) << (SMP_W - w_i);
    pair_done = word_done & word_right;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot      <= '1;
      ws_q      <= 1'b1;
      locked    <= 1'b0;
      sh        <= '0;
      left_hold <= '0;
      rx_valid  <= 1'b0;
      rx_left   <= '0;
      rx_right  <= '0;
    end else begin
      if (rise) begin
        ws_q <= ws;
        slot <= slot_nx;
        if (shift_en) sh <= sh_nx;
        if (new_half) locked <= 1'b1;
      end
      if (word_done && !word_right) left_hold <= aligned;
      if (pair_done) begin
        rx_valid <= 1'b1;
        rx_left  <= left_hold;
        rx_right <= aligned;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_sp_tx.sv
module pcm_sp_tx
  import pcm_sp_pkg::*;
#(
  parameter int SMP_W = 20,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_e             fmt,
  input  logic             fall,
  input  logic [CNT_W-1:0] slot,
  input  logic             ws_q,
  input  logic             locked,
  input  logic             tx_valid,
  input  logic [SMP_W-1:0] tx_left,
  input  logic [SMP_W-1:0] tx_right,
  output logic             tx_ready,
  output logic             sdata
);
  logic [SMP_W-1:0] stg_l, stg_r, cur_l, cur_r, samp, word_w;
  logic             stg_full, last, next_right, frame_start, bitv, accept;
  int               half_i, w_i, ns_i;

  always_comb begin
    half_i      = half_slots(fmt);
    w_i         = word_bits(fmt);
    last        = int'(slot) == half_i - 1;
    ns_i        = last ? 0 : int'(slot) + 1;
    next_right  = last ? ~ws_q : ws_q;
    frame_start = fall & locked & last & ws_q;
    samp        = next_right ? cur_r : cur_l;
    word_w      = SMP_W'(samp[SMP_W-1 -: 16]) << (w_i - 16);
    bitv        = 1'b0;
    if (is_delayed(fmt)) begin
      if (ns_i >= 1 && ns_i <= 16) bitv = word_w[5'(16 - ns_i)];
    end else if (ns_i >= half_i - w_i && ns_i < half_i) begin
      bitv = word_w[5'(half_i - 1 - ns_i)];
    end
    accept = tx_valid & tx_ready;
  end

  assign tx_ready = ~stg_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_full <= 1'b0;
      stg_l    <= '0;
      stg_r    <= '0;
      cur_l    <= '0;
      cur_r    <= '0;
      sdata    <= 1'b0;
    end else begin
      if (fall) sdata <= locked & bitv;
      if (frame_start) begin
        cur_l    <= stg_full ? stg_l : '0;
        cur_r    <= stg_full ? stg_r : '0;
        stg_full <= 1'b0;
      end
      if (accept) begin
        stg_l    <= tx_left;
        stg_r    <= tx_right;
        stg_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_sp_pkg::*;
#(
  parameter int SMP_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt_i,
  input  logic             bclk_i,
  input  logic             wsync_n_i,
  input  logic             sdata_i,
  output logic             sdata_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic [SMP_W-1:0] rx_left_o,
  output logic [SMP_W-1:0] rx_right_o,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  input  logic [SMP_W-1:0] tx_left_i,
  input  logic [SMP_W-1:0] tx_right_i
);
  localparam int MAX_HALF = 32;
  localparam int CNT_W    = $clog2(MAX_HALF) + 1;

  fmt_e             fmt;
  logic             rise_ev, fall_ev, ws_s, sd_s, ws_q, locked, pair_done;
  logic [CNT_W-1:0] slot;

  assign fmt = fmt_e'(fmt_i);

  pcm_sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk(bclk_i), .ws_n(wsync_n_i), .sd(sdata_i),
    .rise(rise_ev), .fall(fall_ev), .ws_s(ws_s), .sd_s(sd_s)
  );

  pcm_sp_rx #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .rise(rise_ev), .ws(ws_s), .sd(sd_s),
    .rx_ready(rx_ready_i), .slot(slot), .ws_q(ws_q), .locked(locked),
    .rx_valid(rx_valid_o), .rx_left(rx_left_o), .rx_right(rx_right_o),
    .pair_done(pair_done)
  );

  pcm_sp_tx #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .fall(fall_ev), .slot(slot),
    .ws_q(ws_q), .locked(locked), .tx_valid(tx_valid_i), .tx_left(tx_left_i),
    .tx_right(tx_right_i), .tx_ready(tx_ready_o), .sdata(sdata_o)
  );
endmodule

// File: rtl/pcm_sp_chk.sv
module pcm_sp_chk #(
  parameter int SMP_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       fmt,
  input logic             fall,
  input logic             pair_done,
  input logic             sdata_o,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [SMP_W-1:0] rx_left,
  input logic [SMP_W-1:0] rx_right,
  input logic             tx_valid,
  input logic             tx_ready
);
  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);

  // R6
  rx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !pair_done |=> $stable(rx_left) && $stable(rx_right));

  // R7
  tx_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);

  // R10
  sdata_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_o != $past(sdata_o)) |-> $past(fall));

  // R11
  rx_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(pair_done));

  // R5
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && fmt == 2'b00 |-> rx_left[3:0] == 4'h0 && rx_right[3:0] == 4'h0);
endmodule

bind pcm_serial_port pcm_sp_chk #(.SMP_W(SMP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fmt(fmt_i), .fall(fall_ev), .pair_done(pair_done),
  .sdata_o(sdata_o), .rx_valid(rx_valid_o), .rx_ready(rx_ready_i),
  .rx_left(rx_left_o), .rx_right(rx_right_o), .tx_valid(tx_valid_i),
  .tx_ready(tx_ready_o)
);

// File: tb/pcm_serial_port_tb_top.sv
`timescale 1ns/1ps
module pcm_serial_port_tb_top;
  localparam int H = 6;
  localparam logic [41:0] VEC [12] = '{
    {2'b00, 20'h0A5C3, 20'h0FF01},
    {2'b00, 20'h08001, 20'h07FFE},
    {2'b00, 20'hF1234, 20'h0ABCD},
    {2'b01, 20'h3FFFF, 20'h00001},
    {2'b01, 20'h2A55A, 20'h15AA5},
    {2'b01, 20'h10000, 20'h2C3D3},
    {2'b10, 20'hFFFFF, 20'h80001},
    {2'b10, 20'h12345, 20'hEDCBA},
    {2'b10, 20'h5A5A5, 20'h00010},
    {2'b11, 20'h0C0DE, 20'h0BEEF},
    {2'b11, 20'h08000, 20'h00001},
    {2'b11, 20'h0FFFF, 20'h05A5A}
  };

  logic        clk = 0, rst_n = 0, bclk = 0, ws_n = 1, sdi = 0;
  logic [1:0]  fmt = 0;
  logic        rx_ready = 1, tx_valid = 0;
  logic [19:0] tx_l = 0, tx_r = 0;
  logic        sdata_o, rx_valid_o, tx_ready_o;
  logic [19:0] rx_left_o, rx_right_o;
  int          nchk = 0, nerr = 0, ncap = 0;
  logic [19:0] cap_l [8];
  logic [19:0] cap_r [8];

  always #2.5 clk = ~clk;

  pcm_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .bclk_i(bclk), .wsync_n_i(ws_n),
    .sdata_i(sdi), .sdata_o(sdata_o), .rx_valid_o(rx_valid_o),
    .rx_ready_i(rx_ready), .rx_left_o(rx_left_o), .rx_right_o(rx_right_o),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready_o), .tx_left_i(tx_l),
    .tx_right_i(tx_r)
  );

  always @(negedge clk) begin
    if (!rst_n) ncap = 0;
    else if (rx_valid_o && rx_ready) begin
      if (ncap < 8) begin cap_l[ncap] = rx_left_o; cap_r[ncap] = rx_right_o; end
      ncap = ncap + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] f);
    return (f == 2'b01) ? 18 : (f == 2'b10) ? 20 : 16;
  endfunction

  function automatic string fmt_req(input logic [1:0] f);
    case (f)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [19:0] exp_rx(input logic [19:0] v, input int w);
    logic [19:0] m;
    m = (20'd1 << w) - 20'd1;
    return (v & m) << (20 - w);
  endfunction

  function automatic logic [19:0] exp_tx(input logic [19:0] v, input int w);
    return 20'(v[19:4]) << (w - 16);
  endfunction

  task automatic do_reset(input logic [1:0] f);
    @(negedge clk);
    rst_n = 0; bclk = 0; ws_n = 1; sdi = 0; tx_valid = 0; fmt = f;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input logic [19:0] lw, input logic [19:0] rw,
                            input bit push, input logic [19:0] tl, input logic [19:0] tr,
                            output logic [19:0] gl, output logic [19:0] gr);
    int  half, w;
    bit  dly, steady;
    half = (fmt == 2'b11) ? 32 : 24;
    w    = wbits(fmt);
    dly  = fmt == 2'b11;
    gl = 0; gr = 0; steady = 1;
    for (int h = 0; h < 2; h++) begin
      for (int s = 0; s < half; s++) begin
        logic [19:0] wd;
        logic        b0, b1;
        bit          inwin, pslot;
        int          idx;
        wd    = h ? rw : lw;
        inwin = dly ? (s >= 1 && s <= 16) : (s >= half - w);
        idx   = dly ? 16 - s : half - 1 - s;
        pslot = push && h == 0 && s == 2;
        @(negedge clk);
        bclk = 0; ws_n = h[0]; sdi = inwin ? wd[idx] : 1'b0;
        if (pslot) begin
          chk("R7 ready before push", {63'd0, tx_ready_o}, 64'd1);
          tx_l = tl; tx_r = tr; tx_valid = 1;
        end
        for (int c = 0; c < H - 1; c++) begin
          @(negedge clk);
          if (pslot && c == 0) tx_valid = 0;
          if (pslot && c == 1) chk("R7 ready after push", {63'd0, tx_ready_o}, 64'd0);
        end
        b0 = sdata_o;
        bclk = 1;
        repeat (H - 1) @(negedge clk);
        b1 = sdata_o;
        if (b0 !== b1) steady = 0;
        if (inwin) begin
          if (h == 1) gr[idx] = b0; else gl[idx] = b0;
        end
      end
    end
    chk("R10 sdata steady in high phase", {63'd0, steady}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [19:0] gl, gr, pl, pr;
    do_reset(2'b00);
    // R11 reset state
    chk("R11 rx_valid", {63'd0, rx_valid_o}, 64'd0);
    chk("R11 tx_ready", {63'd0, tx_ready_o}, 64'd1);
    chk("R11 sdata", {63'd0, sdata_o}, 64'd0);

    pl = 0; pr = 0;
    for (int i = 0; i < 12; i++) begin
      logic [19:0] lw, rw, tl, tr;
      int w;
      lw = VEC[i][39:20]; rw = VEC[i][19:0];
      tl = {lw[9:0], lw[19:10]} ^ 20'h3C96A;
      tr = rw ^ 20'hA5A5A;
      if (i % 3 == 0) begin
        do_reset(VEC[i][41:40]);
        pl = 0; pr = 0;
      end
      w = wbits(fmt);
      send_frame(lw, rw, 1'b1, tl, tr, gl, gr);
      // R8 previous pair out now; R9 first frame after reset is silent
      chk((i % 3 == 0) ? "R9 left" : "R8 left", {44'd0, gl}, {44'd0, exp_tx(pl, w) & ((20'd1 << w) - 20'd1)});
      chk((i % 3 == 0) ? "R9 right" : "R8 right", {44'd0, gr}, {44'd0, exp_tx(pr, w) & ((20'd1 << w) - 20'd1)});
      pl = tl; pr = tr;
      if (i % 3 == 2) begin
        send_frame(20'd0, 20'd0, 1'b0, 20'd0, 20'd0, gl, gr);
        chk("R8 last left", {44'd0, gl}, {44'd0, exp_tx(pl, w) & ((20'd1 << w) - 20'd1)});
        chk("R8 last right", {44'd0, gr}, {44'd0, exp_tx(pr, w) & ((20'd1 << w) - 20'd1)});
        repeat (4) @(negedge clk);
        // R11 no pair from the first transition; R4 delayed format completes the flush pair inside its frame
        chk("R11 pair count", 64'(ncap), (fmt == 2'b11) ? 64'd4 : 64'd3);
        for (int k = 0; k < 3; k++) begin
          chk({fmt_req(fmt), " R5 left"}, {44'd0, cap_l[k]}, {44'd0, exp_rx(VEC[i-2+k][39:20], w)});
          chk({fmt_req(fmt), " R5 right"}, {44'd0, cap_r[k]}, {44'd0, exp_rx(VEC[i-2+k][19:0], w)});
        end
      end
    end

    // R6 back-pressure: latest pair wins and is held
    do_reset(2'b00);
    rx_ready = 0;
    send_frame(20'h01111, 20'h02222, 1'b0, 20'd0, 20'd0, gl, gr);
    send_frame(20'h03333, 20'h04444, 1'b0, 20'd0, 20'd0, gl, gr);
    send_frame(20'h0ABCD, 20'h0DCBA, 1'b0, 20'd0, 20'd0, gl, gr);
    send_frame(20'd0, 20'd0, 1'b0, 20'd0, 20'd0, gl, gr);
    repeat (10) @(negedge clk);
    chk("R6 held valid", {63'd0, rx_valid_o}, 64'd1);
    chk("R6 latest left", {44'd0, rx_left_o}, {44'd0, 20'hABCD0});
    chk("R6 latest right", {44'd0, rx_right_o}, {44'd0, 20'hDCBA0});
    chk("R6 none taken", 64'(ncap), 64'd0);
    rx_ready = 1;
    repeat (2) @(negedge clk);
    chk("R6 taken once", 64'(ncap), 64'd1);
    chk("R6 valid cleared", {63'd0, rx_valid_o}, 64'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule